// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds a parameterised bank of independent down-counting timers behind a flat memory-mapped register space. Each channel has a control word, a reload interval and a live count. All channels advance together on a shared clock-enable tick that stands in for a divided timer clock. When an enabled channel counts down to zero, it records the event in a shared status register and emits a one-clock interrupt pulse on its own output line, provided its bit in the shared enable register is set.

A channel runs in one of two modes. In periodic mode it reloads from its interval on the same tick that finds zero, so its period stays exactly interval+1 ticks. In one-shot mode it stops at zero. Software can force the count back to the interval through the control register at any time. Clock-source and prescaler bits in the control word are kept only as storage. Two watchdog words are also plain storage. Reads return data combinationally from the presented address, and a write takes effect at the clock edge where `wr_en` is high.

Top module: `mmio_interval_timer_bank`

## Requirements
- R1: After reset the enable and status registers read 0, every channel's interval and count read 0, and every channel's control word reads 0x4.
- R2: A write to a channel's interval word (channel n at byte offset 0x14+0x10*n) stores the low CW bits of the data and loads the same value into the count (offset 0x18+0x10*n). Bits above CW read as 0.
- R3: On each cycle with `tick_en` high, a channel whose control bit 0 is 1 and whose count is not zero decrements by one. With bit 0 clear, or with no tick, the count holds.
- R4: With control bit 7 clear, a tick that finds an enabled count at zero is an expiry, and it reloads the interval on that same tick. Successive expiries are therefore exactly interval+1 ticks apart.
- R5: With control bit 7 set, an expiry clears control bit 0 and leaves the count at 0, so the channel raises no further expiries until it is enabled again.
- R6: A write to a channel's control word (offset 0x10+0x10*n) stores all data bits as written. If data bit 1 is set, the same write also loads the count from the interval.
- R7: An expiry of channel n sets bit n of the status register (offset 0x04), whatever the enable register holds.
- R8: A write to the status register clears each status bit that is 1 in the data and leaves the bits written 0 unchanged.
- R9: `irq_o[n]` is high for exactly the one clock after channel n's expiry tick, only if bit n of the enable register (offset 0x00) was set. No other channel's expiry drives it.
- R10: The watchdog control word (offset 0x90) and watchdog mode word (offset 0x94) store and read back all data bits and have no other effect.
- R11: Decoding compares every address bit. A read of any unmapped offset, including windows beyond the last channel and aliases with upper address bits set, returns 0. Writes to unmapped offsets change nothing. The count word is read-only.
- R12: When a bus write to a channel's control or interval word lands in the same cycle as a tick, the write decides the count and that tick is not applied to the channel. When an expiry and a status clear hit the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable tick shared by all channels |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | AW | Byte address of the register accessed |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq_o | output | N_CHAN | Per-channel one-clock interrupt pulse |

## Verification
The bench builds the bank with six channels and a 32-bit bus, so the window right after the last channel (0x70) exists in the address map but decodes to nothing. That makes the beyond-the-bank case of the unmapped-read rule reachable. The count width is narrowed to 16 bits, which selects the zero-extension branch of the readback logic and allows a check that a wide interval write is truncated. Six channels also leave room to run a periodic, a one-shot, an interrupt-masked and a storage-only channel side by side, so cross-channel interrupt isolation can be observed at the pins.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

   // register map (byte offsets)
   localparam int unsigned OFS_IRQ_EN   = 'h00;
   localparam int unsigned OFS_IRQ_STAT = 'h04;
   localparam int unsigned OFS_WD_CTRL  = 'h90;
   localparam int unsigned OFS_WD_MODE  = 'h94;

   // channel windows: base + stride * index
   localparam int unsigned CHAN_BASE    = 'h10;
   localparam int unsigned CHAN_STRIDE  = 'h10;
   localparam int unsigned MAX_CHAN     = 8;

   // offsets inside one channel window
   localparam logic [3:0] WIN_CTRL = 4'h0;
   localparam logic [3:0] WIN_INTV = 4'h4;
   localparam logic [3:0] WIN_CNT  = 4'h8;

   // control word fields
   localparam int unsigned CTRL_RUN_BIT     = 0;
   localparam int unsigned CTRL_RELOAD_BIT  = 1;
   localparam int unsigned CTRL_ONESHOT_BIT = 7;
   localparam int unsigned CTRL_RESET_VAL   = 'h4;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_INTV = 2'd2,
      SEL_CNT  = 2'd3
   } chan_reg_e;

endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
   import tmr_bank_pkg::*;
#(
   parameter int unsigned N_CHAN = 6,
   parameter int unsigned AW     = 32
) (
   input  logic [AW-1:0]     addr,
   output logic              hit_ien,
   output logic              hit_stat,
   output logic              hit_wdc,
   output logic              hit_wdm,
   output logic [N_CHAN-1:0] chan_hit,
   output chan_reg_e         reg_sel
);

   localparam int unsigned WIN_MSB = 7;
   localparam int unsigned WIN_LSB = 4;

   if (AW < 9) begin : g_bad_aw
      $error("tmr_bank_decode: AW must be at least 9");
   end
   if (N_CHAN < 1 || N_CHAN > MAX_CHAN) begin : g_bad_n
      $error("tmr_bank_decode: N_CHAN out of range");
   end

   logic       upper_zero;
   logic [3:0] win_idx;
   logic [3:0] win_ofs;

   assign upper_zero = (addr[AW-1:WIN_MSB+1] == '0);
   assign win_idx    = addr[WIN_MSB:WIN_LSB];
   assign win_ofs    = addr[WIN_LSB-1:0];

   always_comb begin
      unique case (win_ofs)
         WIN_CTRL: reg_sel = SEL_CTRL;
         WIN_INTV: reg_sel = SEL_INTV;
         WIN_CNT:  reg_sel = SEL_CNT;
         default:  reg_sel = SEL_NONE;
      endcase
   end

   for (genvar n = 0; n < N_CHAN; n++) begin : g_win
      assign chan_hit[n] = upper_zero && (reg_sel != SEL_NONE) &&
                           (win_idx == 4'(n + 1));
   end

   assign hit_ien  = (addr == AW'(OFS_IRQ_EN));
   assign hit_stat = (addr == AW'(OFS_IRQ_STAT));
   assign hit_wdc  = (addr == AW'(OFS_WD_CTRL));
   assign hit_wdm  = (addr == AW'(OFS_WD_MODE));

endmodule

// File: rtl/tmr_bank_channel.sv
module tmr_bank_channel
   import tmr_bank_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_ctrl,
   input  logic          wr_intv,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctrl_o,
   output logic [CW-1:0] intv_o,
   output logic [CW-1:0] cnt_o,
   output logic          expire_o
);

   if (DW < 8) begin : g_bad_dw
      $error("tmr_bank_channel: DW must hold control bit 7");
   end
   if (CW < 1 || CW > DW) begin : g_bad_cw
      $error("tmr_bank_channel: CW must be 1..DW");
   end

   logic [DW-1:0] ctrl_q;
   logic [CW-1:0] intv_q;
   logic [CW-1:0] cnt_q;
   logic          wr_any;
   logic          running;
   logic          at_zero;
   logic          expire;

   assign wr_any  = wr_ctrl | wr_intv;
   assign running = ctrl_q[CTRL_RUN_BIT];
   assign at_zero = (cnt_q == '0);
   // bus access owns the channel for the cycle it lands in
   assign expire  = tick && running && at_zero && !wr_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= DW'(CTRL_RESET_VAL);
         intv_q <= '0;
         cnt_q  <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= wdata;
         if (wdata[CTRL_RELOAD_BIT]) begin
            cnt_q <= intv_q;
         end
      end else if (wr_intv) begin
         intv_q <= wdata[CW-1:0];
         cnt_q  <= wdata[CW-1:0];
      end else if (tick && running) begin
         if (at_zero) begin
            if (ctrl_q[CTRL_ONESHOT_BIT]) begin
               ctrl_q[CTRL_RUN_BIT] <= 1'b0;
            end else begin
               cnt_q <= intv_q;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign ctrl_o   = ctrl_q;
   assign intv_o   = intv_q;
   assign cnt_o    = cnt_q;
   assign expire_o = expire;

   // R2: interval write lands in the count
   assert_intv_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_intv && !wr_ctrl) |=> (cnt_q == $past(wdata[CW-1:0])));

   // R3: running, nonzero, ticked -> one less
   assert_tick_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && running && !at_zero && !wr_any) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R3: no effective tick and no bus write -> count frozen
   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && running) && !wr_any) |=> $stable(cnt_q));

   // R4: periodic expiry reloads and keeps running
   assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_q[CTRL_ONESHOT_BIT]) |=>
         ((cnt_q == $past(intv_q)) && ctrl_q[CTRL_RUN_BIT]));

   // R5: one-shot expiry parks the channel at zero
   assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q[CTRL_ONESHOT_BIT]) |=> (!ctrl_q[CTRL_RUN_BIT] && (cnt_q == '0)));

endmodule

// File: rtl/tmr_bank_shared.sv
module tmr_bank_shared #(
   parameter int unsigned N_CHAN = 6,
   parameter int unsigned DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ien,
   input  logic              wr_stat,
   input  logic              wr_wdc,
   input  logic              wr_wdm,
   input  logic [DW-1:0]     wdata,
   input  logic [N_CHAN-1:0] expire,
   output logic [N_CHAN-1:0] ien_o,
   output logic [N_CHAN-1:0] stat_o,
   output logic [DW-1:0]     wdc_o,
   output logic [DW-1:0]     wdm_o,
   output logic [N_CHAN-1:0] irq_o
);

   if (DW < N_CHAN) begin : g_bad_dw
      $error("tmr_bank_shared: DW must cover one bit per channel");
   end

   logic [N_CHAN-1:0] ien_q;
   logic [N_CHAN-1:0] stat_q;
   logic [N_CHAN-1:0] clr_mask;
   logic [N_CHAN-1:0] irq_q;
   logic [DW-1:0]     wdc_q;
   logic [DW-1:0]     wdm_q;

   assign clr_mask = wr_stat ? wdata[N_CHAN-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         stat_q <= '0;
         wdc_q  <= '0;
         wdm_q  <= '0;
      end else begin
         if (wr_ien) ien_q <= wdata[N_CHAN-1:0];
         if (wr_wdc) wdc_q <= wdata;
         if (wr_wdm) wdm_q <= wdata;
         // new events beat a same-cycle clear
         stat_q <= (stat_q & ~clr_mask) | expire;
      end
   end

   for (genvar n = 0; n < N_CHAN; n++) begin : g_irq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q[n] <= 1'b0;
         else        irq_q[n] <= expire[n] & ien_q[n];
      end

      // R9: a pulse needs the channel's enable bit one cycle earlier
      assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_q[n] |-> $past(ien_q[n]));

      // R7 / R12: an expiry always leaves its status bit set
      assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         expire[n] |=> stat_q[n]);
   end

   assign ien_o  = ien_q;
   assign stat_o = stat_q;
   assign wdc_o  = wdc_q;
   assign wdm_o  = wdm_q;
   assign irq_o  = irq_q;

   // R8: write-one-to-clear with no competing event
   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (expire == '0)) |=>
         (stat_q == ($past(stat_q) & ~$past(wdata[N_CHAN-1:0]))));

   // R9: a pulsing line is always backed by a recorded status bit
   assert_irq_has_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_q & ~stat_q) == '0));

endmodule

// File: rtl/mmio_interval_timer_bank.sv
module mmio_interval_timer_bank
   import tmr_bank_pkg::*;
#(
   parameter int unsigned N_CHAN = 6,
   parameter int unsigned AW     = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned CW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic [N_CHAN-1:0] irq_o
);

   if (N_CHAN < 1 || N_CHAN > MAX_CHAN) begin : g_bad_n
      $error("mmio_interval_timer_bank: N_CHAN must be 1..8");
   end
   if (CW < 1 || CW > DW) begin : g_bad_cw
      $error("mmio_interval_timer_bank: CW must be 1..DW");
   end

   logic              hit_ien;
   logic              hit_stat;
   logic              hit_wdc;
   logic              hit_wdm;
   logic [N_CHAN-1:0] chan_hit;
   chan_reg_e         reg_sel;

   logic [N_CHAN-1:0] expire;
   logic [N_CHAN-1:0] ien;
   logic [N_CHAN-1:0] stat;
   logic [DW-1:0]     wdc;
   logic [DW-1:0]     wdm;

   logic [DW-1:0]     ctrl_w   [N_CHAN];
   logic [CW-1:0]     intv_w   [N_CHAN];
   logic [CW-1:0]     cnt_w    [N_CHAN];
   logic [DW-1:0]     intv_ext [N_CHAN];
   logic [DW-1:0]     cnt_ext  [N_CHAN];

   tmr_bank_decode #(
      .N_CHAN (N_CHAN),
      .AW     (AW)
   ) u_decode (
      .addr     (addr),
      .hit_ien  (hit_ien),
      .hit_stat (hit_stat),
      .hit_wdc  (hit_wdc),
      .hit_wdm  (hit_wdm),
      .chan_hit (chan_hit),
      .reg_sel  (reg_sel)
   );

   for (genvar n = 0; n < N_CHAN; n++) begin : g_chan
      logic wr_ctrl_n;
      logic wr_intv_n;

      assign wr_ctrl_n = wr_en && chan_hit[n] && (reg_sel == SEL_CTRL);
      assign wr_intv_n = wr_en && chan_hit[n] && (reg_sel == SEL_INTV);

      tmr_bank_channel #(
         .DW (DW),
         .CW (CW)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick_en),
         .wr_ctrl  (wr_ctrl_n),
         .wr_intv  (wr_intv_n),
         .wdata    (wdata),
         .ctrl_o   (ctrl_w[n]),
         .intv_o   (intv_w[n]),
         .cnt_o    (cnt_w[n]),
         .expire_o (expire[n])
      );

      if (CW < DW) begin : g_narrow
         assign intv_ext[n] = {{(DW - CW){1'b0}}, intv_w[n]};
         assign cnt_ext[n]  = {{(DW - CW){1'b0}}, cnt_w[n]};
      end else begin : g_full
         assign intv_ext[n] = intv_w[n];
         assign cnt_ext[n]  = cnt_w[n];
      end
   end

   tmr_bank_shared #(
      .N_CHAN (N_CHAN),
      .DW     (DW)
   ) u_shared (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ien  (wr_en && hit_ien),
      .wr_stat (wr_en && hit_stat),
      .wr_wdc  (wr_en && hit_wdc),
      .wr_wdm  (wr_en && hit_wdm),
      .wdata   (wdata),
      .expire  (expire),
      .ien_o   (ien),
      .stat_o  (stat),
      .wdc_o   (wdc),
      .wdm_o   (wdm),
      .irq_o   (irq_o)
   );

   always_comb begin
      rdata = '0;
      if (hit_ien) begin
         rdata[N_CHAN-1:0] = ien;
      end else if (hit_stat) begin
         rdata[N_CHAN-1:0] = stat;
      end else if (hit_wdc) begin
         rdata = wdc;
      end else if (hit_wdm) begin
         rdata = wdm;
      end else begin
         for (int n = 0; n < N_CHAN; n++) begin
            if (chan_hit[n]) begin
               unique case (reg_sel)
                  SEL_CTRL: rdata = ctrl_w[n];
                  SEL_INTV: rdata = intv_ext[n];
                  SEL_CNT:  rdata = cnt_ext[n];
                  default:  rdata = '0;
               endcase
            end
         end
      end
   end

   // R11: decoder never selects two targets at once
   assert_decode_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_ien, hit_stat, hit_wdc, hit_wdm, chan_hit}));

   // R11: an address with no target reads as zero
   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(hit_ien || hit_stat || hit_wdc || hit_wdm || (|chan_hit))) |-> (rdata == '0));

endmodule

// File: tb/sim_mmio_interval_timer_bank.sv
`timescale 1ns/1ps
module sim_mmio_interval_timer_bank;

   localparam int NC = 6;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NC-1:0] irq;

   always #2.5 clk = ~clk;

   mmio_interval_timer_bank #(
      .N_CHAN (NC),
      .AW     (AW),
      .DW     (DW),
      .CW     (CW)
   ) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .irq_o   (irq)
   );

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } rd_item_t;

   rd_item_t sb_q[$];
   int       n_chk  = 0;
   int       n_fail = 0;
   logic     rd_pend = 1'b0;
   bit       done = 1'b0;

   function automatic void note(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endfunction

   // monitor: pops the expected item for every read the driver issues
   always @(posedge clk) begin
      if (rd_pend) begin
         rd_item_t it;
         #1;
         if (sb_q.size() == 0) begin
            note(1'b0, "scoreboard underflow", rdata, '0);
         end else begin
            it = sb_q.pop_front();
            note(rdata === it.exp, it.tag, rdata, it.exp);
         end
      end
   end

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit with_tick = 1'b0);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; tick_en = with_tick;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      rd_item_t it;
      @(negedge clk);
      addr = a; rd_pend = 1'b1;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      rd_pend = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic chk_irq(input logic [NC-1:0] exp, input string tag);
      note(irq === exp, tag, DW'(irq), DW'(exp));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_irq('0, "R1 irq idle after reset");
      bus_rd(32'h00, 32'h0, "R1 enable reset");
      bus_rd(32'h04, 32'h0, "R1 status reset");
      bus_rd(32'h10, 32'h4, "R1 ch0 control reset");
      bus_rd(32'h14, 32'h0, "R1 ch0 interval reset");
      bus_rd(32'h18, 32'h0, "R1 ch0 count reset");
      bus_rd(32'h60, 32'h4, "R1 ch5 control reset");

      // R2 interval write, truncated to CW bits, loads count
      bus_wr(32'h14, 32'h0001_0003);
      bus_rd(32'h14, 32'h3, "R2 interval truncated");
      bus_rd(32'h18, 32'h3, "R2 count loaded");

      bus_wr(32'h00, 32'h3);
      bus_rd(32'h00, 32'h3, "R9 enable readback");

      // R3 / R4 periodic channel 0
      bus_wr(32'h10, 32'h1);
      tick(3);
      chk_irq('0, "R4 no expiry before zero");
      bus_rd(32'h18, 32'h0, "R3 count after three ticks");
      tick(1);
      chk_irq(6'b000001, "R9 ch0 pulse on expiry");
      @(negedge clk);
      chk_irq('0, "R9 pulse lasts one clock");
      bus_rd(32'h18, 32'h3, "R4 same-tick reload");
      bus_rd(32'h04, 32'h1, "R7 status bit0 set");
      tick(3);
      chk_irq('0, "R4 no early expiry");
      tick(1);
      chk_irq(6'b000001, "R4 period interval+1");

      // R8 write-one-to-clear
      bus_wr(32'h04, 32'h0);
      bus_rd(32'h04, 32'h1, "R8 zero write keeps bit");
      bus_wr(32'h04, 32'hFFFF_FFFE);
      bus_rd(32'h04, 32'h1, "R8 other bits written");
      bus_wr(32'h04, 32'h1);
      bus_rd(32'h04, 32'h0, "R8 bit cleared");

      // R3 hold while disabled
      tick(1);
      bus_wr(32'h10, 32'h0);
      tick(2);
      bus_rd(32'h18, 32'h2, "R3 disabled count holds");

      // R6 forced reload via control
      bus_wr(32'h10, 32'h3);
      bus_rd(32'h18, 32'h3, "R6 reload from control");
      bus_rd(32'h10, 32'h3, "R6 control stored");

      // R5 one-shot channel 1
      bus_wr(32'h24, 32'h2);
      bus_wr(32'h20, 32'h81);
      tick(2);
      chk_irq('0, "R5 one-shot counting");
      tick(1);
      chk_irq(6'b000010, "R5 one-shot expiry pulse");
      bus_rd(32'h20, 32'h80, "R5 run bit cleared");
      bus_rd(32'h28, 32'h0, "R5 count parked at zero");
      tick(1);
      chk_irq(6'b000001, "R9 ch0 expiry does not re-signal ch1");
      tick(3);
      chk_irq('0, "R5 no further one-shot expiry");
      bus_rd(32'h28, 32'h0, "R5 count still zero");
      bus_rd(32'h04, 32'h3, "R7 both status bits");

      // R7 / R9 masked channel 2
      bus_wr(32'h10, 32'h0);
      bus_wr(32'h04, 32'h3);
      bus_wr(32'h30, 32'h1);
      tick(1);
      chk_irq('0, "R9 masked channel no pulse");
      bus_rd(32'h04, 32'h4, "R7 status set while masked");

      // R12 bus write wins over tick
      bus_wr(32'h04, 32'h4);
      bus_wr(32'h34, 32'h5, 1'b1);
      bus_rd(32'h38, 32'h5, "R12 write beats tick");
      bus_rd(32'h04, 32'h0, "R12 no expiry under write");

      // R10 watchdog storage
      bus_wr(32'h90, 32'hA5A5_0001);
      bus_wr(32'h94, 32'h0000_00F3);
      bus_rd(32'h90, 32'hA5A5_0001, "R10 watchdog control");
      bus_rd(32'h94, 32'h0000_00F3, "R10 watchdog mode");

      // R6 control bits kept as storage
      bus_wr(32'h40, 32'h74);
      bus_rd(32'h40, 32'h74, "R6 ch3 control storage");
      bus_rd(32'h48, 32'h0, "R6 no reload without bit1");

      // R11 unmapped and read-only
      bus_wr(32'h18, 32'h77);
      bus_rd(32'h18, 32'h0, "R11 count read-only");
      bus_wr(32'hA0, 32'h1234);
      bus_rd(32'hA0, 32'h0, "R11 unmapped reads zero");
      bus_wr(32'h210, 32'hFF);
      bus_rd(32'h10, 32'h0, "R11 alias write ignored");
      bus_rd(32'h210, 32'h0, "R11 alias reads zero");
      bus_wr(32'h74, 32'h9);
      bus_rd(32'h74, 32'h0, "R11 window past last channel");
      bus_rd(32'h1C, 32'h0, "R11 hole inside window");

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         note(1'b0, "watchdog expired", '0, 32'h1);
         summary();
         $finish;
      end
   end

endmodule